// File: doc/BRIEF.md
# Relative Branch Resolver with Idle-Loop Watch

This block takes one instruction at a time and settles how it affects control flow, provided the instruction is a relative branch. It decides from the opcode whether the instruction is a branch at all. The opcode also selects one status flag and the value that flag must hold for the branch to be taken. The block computes the taken target from the program counter and a signed 8-bit displacement. It returns the next program counter and the number of clock cycles the instruction costs. All of that is combinational from the inputs.

Beside that path sits a small registered watcher that looks for a tight idle loop. It keeps the most recent taken target. It counts how often a taken branch goes backward to that same target again. Once the count passes a programmable limit it raises a flag, which lets the surrounding core skip or report a spin-wait. A strobe marks the cycles in which an instruction really executes, so the watcher only moves on those cycles. A synchronous clear empties it.

Top module: `branch_unit`

## Requirements
- R1: An opcode is a branch exactly when its low five bits are 5'b10000; for any other opcode `taken` is 0, `next_pc` is `pc`+2 and `cycles` is 2.
- R2: Opcode bits 7:6 pick the tested flag from `status`: 2'b00 tests bit 7 (negative), 2'b01 tests bit 6 (overflow), 2'b10 tests bit 0 (carry), 2'b11 tests bit 1 (zero).
- R3: A branch is taken when the selected flag equals opcode bit 5.
- R4: A taken branch gives `next_pc` = `pc` + 2 + sign-extended `offset`, modulo 2^16.
- R5: A branch that is not taken gives `next_pc` = `pc` + 2 and `cycles` = 2.
- R6: A taken branch costs 3 cycles, or 4 when the target's upper byte differs from the upper byte of `pc`+2.
- R7: When `exec_en` is high and a branch is taken to the recorded target with `offset` bit 7 set, the loop count rises by one (saturating). A forward taken branch to that target leaves it unchanged. So does a cycle with no taken branch, a cycle with a non-branch opcode, or a cycle with `exec_en` low.
- R8: When `exec_en` is high and a branch is taken to a target other than the recorded one, or to any target while none is recorded, the target is recorded and the count becomes 1.
- R9: `loop_hit` is high from the clock edge on which the count goes above 999 and stays high until cleared, so it rises after 1000 taken branches to one target, all but the first of them backward.
- R10: `rst` or `clear` high at a clock edge sets the count to 0, forgets the recorded target and drops `loop_hit`; `clear` wins over a simultaneous taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of the loop watcher |
| exec_en | input | 1 | High in a cycle in which the presented instruction executes |
| opcode | input | 8 | Instruction opcode |
| offset | input | 8 | Signed branch displacement |
| pc | input | 16 | Address of the branch instruction |
| status | input | 8 | Processor status flags |
| is_branch | output | 1 | Opcode is a relative branch |
| taken | output | 1 | Branch condition met |
| next_pc | output | 16 | Address of the next instruction |
| cycles | output | 3 | Cycle cost of the instruction |
| loop_hit | output | 1 | Idle loop detected |

## Verification
The assertions take for granted that every input is a known value once reset has been applied, and that `clear` and `exec_en` are plain level inputs sampled at each rising edge. The bench drives all inputs from the falling edge and holds them through the next rising edge, so each input is settled and defined wherever a property samples it. Random opcodes are pushed half the time onto the branch pattern, so both the branch path and the non-branch path get plenty of traffic. Random status bytes and displacements then reach every flag selector, both polarities and both page outcomes. The long loop sequences drive the counter through its limit. Along the way they pass through new-target restarts, forward branches, idle cycles and clear cycles, and the counter stays within its declared width throughout.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int OP_W      = 8;
    localparam int OFF_W     = 8;
    localparam int CYC_W     = 3;
    localparam logic [4:0] BR_PATTERN = 5'b10000;

    localparam int ST_NEG = 7;
    localparam int ST_OVF = 6;
    localparam int ST_ZRO = 1;
    localparam int ST_CRY = 0;

    localparam logic [CYC_W-1:0] CYC_BASE = 3'd2;

    typedef enum logic [1:0] {
        FLG_NEG = 2'b00,
        FLG_OVF = 2'b01,
        FLG_CRY = 2'b10,
        FLG_ZRO = 2'b11
    } flag_sel_e;

    typedef struct packed {
        logic      is_br;
        flag_sel_e sel;
        logic      want;
    } br_dec_t;

    function automatic br_dec_t decode_op(input logic [OP_W-1:0] op);
        br_dec_t d;
        d.is_br = (op[4:0] == BR_PATTERN);
        d.sel   = flag_sel_e'(op[7:6]);
        d.want  = op[5];
        return d;
    endfunction

    function automatic logic pick_flag(input flag_sel_e s, input logic [7:0] st);
        logic f;
        unique case (s)
            FLG_NEG: f = st[ST_NEG];
            FLG_OVF: f = st[ST_OVF];
            FLG_CRY: f = st[ST_CRY];
            default: f = st[ST_ZRO];
        endcase
        return f;
    endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [7:0]      status,
    output br_dec_t         dec,
    output logic            taken
);
    always_comb begin
        dec   = decode_op(opcode);
        taken = dec.is_br && (pick_flag(dec.sel, status) == dec.want);
    end
endmodule

// File: rtl/bru_target.sv
module bru_target
    import bru_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic             taken,
    output logic [PC_W-1:0]  target,
    output logic [PC_W-1:0]  next_pc,
    output logic [CYC_W-1:0] cycles
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] seq_pc;
    logic            page_cross;

    always_comb begin
        seq_pc     = pc + PC_W'(2);
        target     = seq_pc + {{EXT_W{offset[OFF_W-1]}}, offset};
        page_cross = (target[PC_W-1:8] != seq_pc[PC_W-1:8]);
        next_pc    = taken ? target : seq_pc;
        cycles     = CYC_BASE + CYC_W'(taken) + CYC_W'(taken && page_cross);
    end
endmodule

// File: rtl/bru_loopdet.sv
module bru_loopdet
    import bru_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int LOOP_LIMIT = 999
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            fire,
    input  logic            backward,
    input  logic [PC_W-1:0] target,
    output logic            loop_hit
);
    localparam int CNT_W = $clog2(LOOP_LIMIT + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LOOP_LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic [PC_W-1:0]  tgt_q;
    logic             have_q;
    logic             same_tgt;

    assign same_tgt = have_q && (target == tgt_q);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            tgt_q  <= '0;
            have_q <= 1'b0;
        end else if (fire) begin
            if (!same_tgt) begin
                cnt_q  <= CNT_W'(1);
                tgt_q  <= target;
                have_q <= 1'b1;
            end else if (backward && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign loop_hit = cnt_q > CNT_LIM;

    AST_NEW_TARGET_ONE: assert property (@(posedge clk) disable iff (rst)
        (fire && !clear && !same_tgt) |=> (cnt_q == CNT_W'(1))); // R8
    AST_FORWARD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fire && !clear && same_tgt && !backward) |=> $stable(cnt_q)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fire && !clear) |=> ($stable(cnt_q) && $stable(tgt_q))); // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!loop_hit && cnt_q == '0)); // R10
    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (loop_hit && !clear && !(fire && !same_tgt)) |=> loop_hit); // R9
endmodule

// File: rtl/branch_unit.sv
module branch_unit
    import bru_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int LOOP_LIMIT = 999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             exec_en,
    input  logic [7:0]       opcode,
    input  logic [7:0]       offset,
    input  logic [PC_W-1:0]  pc,
    input  logic [7:0]       status,
    output logic             is_branch,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc,
    output logic [2:0]       cycles,
    output logic             loop_hit
);
    br_dec_t         dec;
    logic [PC_W-1:0] target;

    bru_decode u_decode (
        .opcode (opcode),
        .status (status),
        .dec    (dec),
        .taken  (taken)
    );

    assign is_branch = dec.is_br;

    bru_target #(.PC_W(PC_W)) u_target (
        .pc      (pc),
        .offset  (offset),
        .taken   (taken),
        .target  (target),
        .next_pc (next_pc),
        .cycles  (cycles)
    );

    bru_loopdet #(.PC_W(PC_W), .LOOP_LIMIT(LOOP_LIMIT)) u_loopdet (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .fire     (exec_en && taken),
        .backward (offset[OFF_W-1]),
        .target   (target),
        .loop_hit (loop_hit)
    );

    AST_TAKEN_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (rst)
        taken |-> is_branch); // R1
    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
        !taken |-> (cycles == 3'd2 && next_pc == pc + PC_W'(2))); // R5
    AST_TAKEN_COST: assert property (@(posedge clk) disable iff (rst)
        taken |-> (cycles == 3'd3 || cycles == 3'd4)); // R6
    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> !loop_hit); // R10
endmodule

// File: tb/branch_unit_bench.sv
module branch_unit_bench;
    logic        clk = 1'b0;
    logic        rst, clear, exec_en;
    logic [7:0]  opcode, offset, status;
    logic [15:0] pc;
    logic        is_branch, taken, loop_hit;
    logic [15:0] next_pc;
    logic [2:0]  cycles;

    int n_chk = 0;
    int n_bad = 0;

    int  m_cnt  = 0;
    bit  m_have = 0;
    logic [15:0] m_tgt = '0;

    always #2 clk = ~clk;

    branch_unit u_branch_unit (
        .clk(clk), .rst(rst), .clear(clear), .exec_en(exec_en),
        .opcode(opcode), .offset(offset), .pc(pc), .status(status),
        .is_branch(is_branch), .taken(taken), .next_pc(next_pc),
        .cycles(cycles), .loop_hit(loop_hit)
    );

    function automatic bit f_isbr(input logic [7:0] op);
        return op[4:0] == 5'h10;
    endfunction

    function automatic bit f_taken(input logic [7:0] op, input logic [7:0] st);
        bit fl;
        case (op[7:6])
            2'd0: fl = st[7];
            2'd1: fl = st[6];
            2'd2: fl = st[0];
            default: fl = st[1];
        endcase
        return f_isbr(op) && (fl == op[5]);
    endfunction

    function automatic logic [15:0] f_tgt(input logic [15:0] p, input logic [7:0] o);
        return p + 16'd2 + {{8{o[7]}}, o};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] op, input logic [7:0] off,
                         input logic [15:0] p, input logic [7:0] st,
                         input bit en, input bit clr);
        bit          e_tk;
        logic [15:0] e_tg, e_np, seq;
        int          e_cy;
        @(negedge clk);
        chk(loop_hit == (m_cnt > 999), "R9 loop_hit", loop_hit, m_cnt > 999);
        opcode = op; offset = off; pc = p; status = st; exec_en = en; clear = clr;
        #1;
        e_tk = f_taken(op, st);
        e_tg = f_tgt(p, off);
        seq  = p + 16'd2;
        e_np = e_tk ? e_tg : seq;
        e_cy = 2 + (e_tk ? 1 : 0) + ((e_tk && e_tg[15:8] != seq[15:8]) ? 1 : 0);
        chk(is_branch == f_isbr(op), "R1 is_branch", is_branch, f_isbr(op));
        chk(taken == e_tk, "R1/R2/R3 taken", taken, e_tk);
        chk(next_pc == e_np, e_tk ? "R4 next_pc" : "R5 next_pc", next_pc, e_np);
        chk(int'(cycles) == e_cy, e_tk ? "R6 cycles" : "R5 cycles", cycles, e_cy);
        if (clr) begin
            m_cnt = 0; m_have = 0; m_tgt = '0;
        end else if (en && e_tk) begin
            if (!m_have || e_tg != m_tgt) begin
                m_cnt = 1; m_have = 1; m_tgt = e_tg;
            end else if (off[7] && m_cnt < 1023) begin
                m_cnt++;
            end
        end
    endtask

    task automatic hit_is(input bit exp, input string req);
        apply(8'h00, 8'h00, 16'h1000, 8'h00, 1'b0, 1'b0);
        #1;
        chk(loop_hit == exp, req, loop_hit, exp);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        rst = 1'b1; clear = 1'b0; exec_en = 1'b0;
        opcode = '0; offset = '0; pc = '0; status = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(loop_hit == 1'b0, "R10 reset loop_hit", loop_hit, 0);

        // directed decode and timing corners (R2 R3 R4 R5 R6)
        apply(8'h10, 8'h05, 16'h1234, 8'h00, 1'b0, 1'b0); // N clear, want 0: taken
        apply(8'h30, 8'h05, 16'h1234, 8'h00, 1'b0, 1'b0); // want N=1: not taken
        apply(8'h50, 8'h80, 16'h0300, 8'h40, 1'b0, 1'b0); // V=1 want 0: not taken
        apply(8'h70, 8'h80, 16'h0300, 8'h40, 1'b0, 1'b0); // backward across page
        apply(8'hB0, 8'hFD, 16'h20FE, 8'h01, 1'b0, 1'b0); // carry set, target 0x20FD
        apply(8'hF0, 8'h7F, 16'h10F0, 8'h02, 1'b0, 1'b0); // zero set, forward cross
        apply(8'hD0, 8'h01, 16'hFFFD, 8'h00, 1'b0, 1'b0); // wrap past 0xFFFF
        apply(8'h90, 8'h00, 16'h00FE, 8'h00, 1'b0, 1'b0); // seq already on new page
        apply(8'h4C, 8'h10, 16'h4000, 8'hFF, 1'b0, 1'b0); // non-branch R1

        // random traffic, exec_en low so watcher idles
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op = 8'($urandom);
            if ($urandom % 2) op[4:0] = 5'h10;
            apply(op, 8'($urandom), 16'($urandom), 8'($urandom), 1'b0, 1'b0);
        end

        // R8 R7 R9: reach the limit exactly
        for (int i = 0; i < 999; i++)
            apply(8'hD0, 8'hFC, 16'h0250, 8'h00, 1'b1, 1'b0);
        hit_is(1'b0, "R9 count 999 no hit");
        // ignored stimulus: not-taken branch, non-branch, exec_en low (R7)
        apply(8'hF0, 8'hFC, 16'h0250, 8'h00, 1'b1, 1'b0);
        apply(8'hEA, 8'hFC, 16'h0250, 8'h00, 1'b1, 1'b0);
        apply(8'hD0, 8'hFC, 16'h0250, 8'h00, 1'b0, 1'b0);
        hit_is(1'b0, "R7 ignored ops keep count");
        apply(8'hD0, 8'hFC, 16'h0250, 8'h00, 1'b1, 1'b0);
        hit_is(1'b1, "R9 count 1000 hit");
        hit_is(1'b1, "R9 hit holds");
        // clear beats simultaneous taken branch (R10)
        apply(8'hD0, 8'hFC, 16'h0250, 8'h00, 1'b1, 1'b1);
        hit_is(1'b0, "R10 clear");

        // forward repeats do not count (R7)
        for (int i = 0; i < 1100; i++)
            apply(8'hD0, 8'h04, 16'h0800, 8'h00, 1'b1, 1'b0);
        hit_is(1'b0, "R7 forward no count");

        // new target restarts count (R8)
        apply(8'hD0, 8'hF0, 16'h0900, 8'h00, 1'b1, 1'b0);
        for (int i = 0; i < 998; i++)
            apply(8'hD0, 8'hF0, 16'h0900, 8'h00, 1'b1, 1'b0);
        apply(8'hD0, 8'hF0, 16'h0A00, 8'h00, 1'b1, 1'b0);
        apply(8'hD0, 8'hF0, 16'h0900, 8'h00, 1'b1, 1'b0);
        hit_is(1'b0, "R8 restart on new target");
        for (int i = 0; i < 999; i++)
            apply(8'hD0, 8'hF0, 16'h0900, 8'h00, 1'b1, 1'b0);
        hit_is(1'b1, "R8 R9 hit after restart");

        // reset clears too (R10)
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_cnt = 0; m_have = 0;
        #1;
        chk(loop_hit == 1'b0, "R10 reset mid-run", loop_hit, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule